// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a multi-cycle datapath built around a stored microprogram. A micro-program counter (micro-PC) selects one word of an internal control store, and the control-signal part of that word is presented on the output in the same cycle. Every word also carries a next-address field, a two-bit sequencing mode, a condition select bit and a condition polarity bit. Together these decide where the micro-PC goes on the next clock edge. It can step to the following word, jump to the field, dispatch through an opcode table, or test the zero flag or the memory-ready flag.

The store is loaded with a built-in test routine whenever reset is applied. While the sequencer is halted, software can patch any word through a load port, which changes the machine's behaviour without touching the logic. A run-enable input gates sequencing. While it is low the micro-PC holds and the load port is open. While it is high the micro-PC advances and loads are dropped.

Top module: `useq_top`

## Requirements
- R1: A microinstruction word is {ctrl[CTRL_W-1:0], field[UADDR_W-1:0], inv, sel, mode[1:0]}, with mode in bits 1:0, sel in bit 2, inv in bit 3 and field starting at bit 4. The output ctrl_word equals the ctrl part of the word at address upc in the same cycle.
- R2: While rst_n is low, upc is 0 and every store word is set to its default contents.
- R3: While run_en is low, upc keeps its value across clock edges.
- R4: Mode 00 (increment) moves upc to upc+1 on the next edge, wrapping from the top address to 0.
- R5: Mode 01 (jump) moves upc to the word's field.
- R6: Mode 10 (dispatch) moves upc to the dispatch-table entry for the opcode input, which is DISP_BASE + DISP_STRIDE*opcode (8 + 2*opcode by default).
- R7: Mode 11 (conditional) tests zero_flag when sel is 0 and mem_ready when sel is 1, with the result inverted when inv is 1. A true test loads the field, and a false test increments.
- R8: A conditional word with sel=1, inv=1 and field equal to its own address holds upc while mem_ready is low, and steps to the next address in the first cycle that mem_ready is high.
- R9: With run_en low, ld_we high writes ld_data to word ld_addr at the clock edge, and the new word is in effect from the following cycle.
- R10: A load issued while run_en is high leaves the store unchanged.
- R11: The default word at address a has ctrl = a with bit CTRL_W-1 set and field 0. Address 1 uses mode dispatch, odd addresses at or above DISP_BASE use mode jump (to 0), and all others use mode increment. With defaults, opcode k therefore runs 0, 1, 8+2k, 9+2k, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears upc and restores the default store |
| run_en | input | 1 | Sequencing enable; also closes the load port |
| opcode | input | OPC_W | Instruction opcode used by dispatch mode |
| zero_flag | input | 1 | Datapath zero condition |
| mem_ready | input | 1 | Memory ready condition |
| ld_we | input | 1 | Store write strobe |
| ld_addr | input | UADDR_W | Store write address |
| ld_data | input | CTRL_W+UADDR_W+4 | Store write word |
| upc | output | UADDR_W | Current micro-PC |
| ctrl_word | output | CTRL_W | Control signals for the current cycle |

## Verification
In the same cycle, a store write and the sequencer's own advance can both be requested. The bench provokes this by raising ld_we for address 1, with a junk word, in the cycle where the running sequencer sits at address 0 and is about to step to address 1. The write must lose. This is judged one cycle later at the ports: ctrl_word must show the default contents of address 1, and the next step must still follow the default dispatch to 8 + 2*opcode. A second collision holds mem_ready low across a self-looping wait word and then raises it, and upc must leave the loop in exactly that cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {
      SEQ_INC  = 2'b00,
      SEQ_JMP  = 2'b01,
      SEQ_DISP = 2'b10,
      SEQ_COND = 2'b11
   } seq_mode_e;

   localparam int unsigned MODE_LSB = 0;
   localparam int unsigned SEL_BIT  = 2;
   localparam int unsigned INV_BIT  = 3;
   localparam int unsigned FIELD_LSB = 4;
   localparam int unsigned HDR_W    = 4;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
   parameter int unsigned CTRL_W    = 16,
   parameter int unsigned UADDR_W   = 6,
   parameter int unsigned DISP_BASE = 8,
   localparam int unsigned WORD_W   = CTRL_W + UADDR_W + useq_pkg::HDR_W,
   localparam int unsigned DEPTH    = 1 << UADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [UADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0]  wdata,
   input  logic [UADDR_W-1:0] raddr,
   output logic [WORD_W-1:0]  rdata
);
   import useq_pkg::*;

   logic [WORD_W-1:0] mem [DEPTH];

   function automatic logic [WORD_W-1:0] dflt_word(input int unsigned a);
      logic [CTRL_W-1:0] c;
      seq_mode_e         m;
      c = CTRL_W'(a);
      c[CTRL_W-1] = 1'b1;
      if (a == 1)
         m = SEQ_DISP;
      else if ((a >= DISP_BASE) && (a % 2 == 1))
         m = SEQ_JMP;
      else
         m = SEQ_INC;
      return {c, {UADDR_W{1'b0}}, 1'b0, 1'b0, m};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= dflt_word(a);
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
   parameter int unsigned OPC_W       = 3,
   parameter int unsigned UADDR_W     = 6,
   parameter int unsigned DISP_BASE   = 8,
   parameter int unsigned DISP_STRIDE = 2,
   localparam int unsigned N_OPC      = 1 << OPC_W
) (
   input  logic [OPC_W-1:0]   opcode,
   output logic [UADDR_W-1:0] target
);
   logic [UADDR_W-1:0] table_q [N_OPC];

   for (genvar k = 0; k < N_OPC; k++) begin : g_entry
      assign table_q[k] = UADDR_W'(DISP_BASE + k * DISP_STRIDE);
   end

   assign target = table_q[opcode];

endmodule

// File: rtl/useq_next.sv
module useq_next #(
   parameter int unsigned UADDR_W = 6
) (
   input  useq_pkg::seq_mode_e mode,
   input  logic                sel,
   input  logic                inv,
   input  logic [UADDR_W-1:0]  field,
   input  logic [UADDR_W-1:0]  cur,
   input  logic [UADDR_W-1:0]  disp,
   input  logic                zero_flag,
   input  logic                mem_ready,
   output logic [UADDR_W-1:0]  nxt
);
   import useq_pkg::*;

   logic               test_raw;
   logic               test_ok;
   logic [UADDR_W-1:0] seq_addr;

   assign test_raw = sel ? mem_ready : zero_flag;
   assign test_ok  = test_raw ^ inv;
   assign seq_addr = cur + UADDR_W'(1);

   always_comb begin
      unique case (mode)
         SEQ_INC:  nxt = seq_addr;
         SEQ_JMP:  nxt = field;
         SEQ_DISP: nxt = disp;
         SEQ_COND: nxt = test_ok ? field : seq_addr;
         default:  nxt = seq_addr;
      endcase
   end

endmodule

// File: rtl/useq_top.sv
module useq_top #(
   parameter int unsigned CTRL_W      = 16,
   parameter int unsigned UADDR_W     = 6,
   parameter int unsigned OPC_W       = 3,
   parameter int unsigned DISP_BASE   = 8,
   parameter int unsigned DISP_STRIDE = 2,
   localparam int unsigned WORD_W     = CTRL_W + UADDR_W + useq_pkg::HDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_en,
   input  logic [OPC_W-1:0]   opcode,
   input  logic               zero_flag,
   input  logic               mem_ready,
   input  logic               ld_we,
   input  logic [UADDR_W-1:0] ld_addr,
   input  logic [WORD_W-1:0]  ld_data,
   output logic [UADDR_W-1:0] upc,
   output logic [CTRL_W-1:0]  ctrl_word
);
   import useq_pkg::*;

   if (CTRL_W < 2) begin : g_bad_ctrl
      $error("useq_top: CTRL_W must be at least 2");
   end
   if (UADDR_W < 2 || UADDR_W > 12) begin : g_bad_addr
      $error("useq_top: UADDR_W out of range");
   end
   if (DISP_STRIDE == 0) begin : g_bad_stride
      $error("useq_top: DISP_STRIDE must be nonzero");
   end
   if (DISP_BASE + ((1 << OPC_W) - 1) * DISP_STRIDE >= (1 << UADDR_W)) begin : g_bad_disp
      $error("useq_top: dispatch targets exceed the control store");
   end

   logic [WORD_W-1:0]  cur_word;
   seq_mode_e          cur_mode;
   logic               cur_sel;
   logic               cur_inv;
   logic [UADDR_W-1:0] cur_field;
   logic [UADDR_W-1:0] disp_addr;
   logic [UADDR_W-1:0] upc_nxt;
   logic               store_we;

   assign store_we = ld_we & ~run_en;

   useq_store #(
      .CTRL_W   (CTRL_W),
      .UADDR_W  (UADDR_W),
      .DISP_BASE(DISP_BASE)
   ) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (store_we),
      .waddr(ld_addr),
      .wdata(ld_data),
      .raddr(upc),
      .rdata(cur_word)
   );

   assign cur_mode  = seq_mode_e'(cur_word[MODE_LSB +: 2]);
   assign cur_sel   = cur_word[SEL_BIT];
   assign cur_inv   = cur_word[INV_BIT];
   assign cur_field = cur_word[FIELD_LSB +: UADDR_W];
   assign ctrl_word = cur_word[WORD_W-1 -: CTRL_W];

   useq_dispatch #(
      .OPC_W      (OPC_W),
      .UADDR_W    (UADDR_W),
      .DISP_BASE  (DISP_BASE),
      .DISP_STRIDE(DISP_STRIDE)
   ) u_disp (
      .opcode(opcode),
      .target(disp_addr)
   );

   useq_next #(
      .UADDR_W(UADDR_W)
   ) u_next (
      .mode     (cur_mode),
      .sel      (cur_sel),
      .inv      (cur_inv),
      .field    (cur_field),
      .cur      (upc),
      .disp     (disp_addr),
      .zero_flag(zero_flag),
      .mem_ready(mem_ready),
      .nxt      (upc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         upc <= '0;
      else if (run_en)
         upc <= upc_nxt;
   end

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
   parameter int unsigned UADDR_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run_en,
   input logic               mem_ready,
   input logic [1:0]         mode,
   input logic               sel,
   input logic               inv,
   input logic [UADDR_W-1:0] field,
   input logic [UADDR_W-1:0] disp_addr,
   input logic [UADDR_W-1:0] upc
);
   // R2: the first edge out of reset finds the micro-PC at zero
   a_r2_reset_zero: assert property (@(posedge clk) $rose(rst_n) |-> (upc == '0));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(upc));

   a_r4_increment: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && mode == 2'b00) |=> (upc == UADDR_W'($past(upc) + 1)));

   a_r5_jump: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && mode == 2'b01) |=> (upc == $past(field)));

   a_r6_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && mode == 2'b10) |=> (upc == $past(disp_addr)));

   a_r8_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && mode == 2'b11 && sel && inv && !mem_ready && field == upc) |=> $stable(upc));

   // R7: a conditional word leaves only to its field or to the next address
   a_r7_cond_target: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && mode == 2'b11) |=> (upc == $past(field) || upc == UADDR_W'($past(upc) + 1)));

endmodule

bind useq_top useq_chk #(.UADDR_W(UADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .mem_ready(mem_ready),
   .mode     (cur_mode),
   .sel      (cur_sel),
   .inv      (cur_inv),
   .field    (cur_field),
   .disp_addr(disp_addr),
   .upc      (upc)
);

// File: tb/tb_useq_top.sv
module tb_useq_top;
   localparam int CW = 16;
   localparam int AW = 6;
   localparam int OW = 3;
   localparam int WW = CW + AW + 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic [OW-1:0] opcode = '0;
   logic          zero_flag = 1'b0;
   logic          mem_ready = 1'b0;
   logic          ld_we = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [WW-1:0] ld_data = '0;
   logic [AW-1:0] upc;
   logic [CW-1:0] ctrl_word;

   int n_tests = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   useq_top dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .opcode(opcode),
      .zero_flag(zero_flag), .mem_ready(mem_ready), .ld_we(ld_we),
      .ld_addr(ld_addr), .ld_data(ld_data), .upc(upc), .ctrl_word(ctrl_word)
   );

   function automatic logic [WW-1:0] mk(input logic [CW-1:0] c, input int f,
                                        input bit inv, input bit sel, input logic [1:0] m);
      return {c, AW'(f), inv, sel, m};
   endfunction

   function automatic logic [CW-1:0] dctrl(input int a);
      return CW'(a) | CW'(16'h8000);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; run_en = 1'b0; ld_we = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R2 upc after reset", upc, 0);
      chk("R11 R1 ctrl at word 0", ctrl_word, dctrl(0));
   endtask

   task automatic t_default(input int op);
      do_reset();
      opcode = OW'(op);
      run_en = 1'b1;
      step();
      chk("R11 step to 1", upc, 1);
      chk("R1 ctrl at 1", ctrl_word, dctrl(1));
      step();
      chk("R6 dispatch target", upc, 8 + 2 * op);
      chk("R1 ctrl at target", ctrl_word, dctrl(8 + 2 * op));
      step();
      chk("R4 increment after target", upc, 9 + 2 * op);
      step();
      chk("R11 default jump home", upc, 0);
      run_en = 1'b0;
   endtask

   task automatic t_hold();
      do_reset();
      run_en = 1'b1;
      step();
      run_en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R3 hold while halted", upc, 1);
      end
   endtask

   task automatic t_ignore();
      do_reset();
      opcode = 3'd2;
      run_en = 1'b1;
      ld_we = 1'b1; ld_addr = 6'd1; ld_data = mk(16'h1234, 40, 1'b0, 1'b0, 2'b01);
      step();
      ld_we = 1'b0;
      chk("R10 moved to 1", upc, 1);
      chk("R10 word 1 unchanged", ctrl_word, dctrl(1));
      step();
      chk("R10 dispatch intact", upc, 12);
      run_en = 1'b0;
   endtask

   task automatic load(input int a, input logic [WW-1:0] w);
      ld_we = 1'b1; ld_addr = AW'(a); ld_data = w;
      step();
      ld_we = 1'b0;
   endtask

   task automatic t_patch();
      do_reset();
      load(0, mk(16'hA000, 5, 1'b0, 1'b0, 2'b01));
      chk("R9 patched word 0 in effect", ctrl_word, 16'hA000);
      load(5, mk(16'hA005, 10, 1'b0, 1'b0, 2'b11));
      load(10, mk(16'hA00A, 10, 1'b1, 1'b1, 2'b11));
      load(11, mk(16'hA00B, 0, 1'b0, 1'b0, 2'b10));
      load(6, mk(16'hA006, 0, 1'b0, 1'b0, 2'b00));
      load(7, mk(16'hA007, 63, 1'b0, 1'b0, 2'b01));
      load(63, mk(16'hA03F, 0, 1'b0, 1'b0, 2'b00));
      // pass 1: zero true, then a memory wait, then dispatch
      zero_flag = 1'b1; mem_ready = 1'b0; opcode = 3'd7;
      run_en = 1'b1;
      step();
      chk("R5 jump to field", upc, 5);
      step();
      chk("R7 zero true taken", upc, 10);
      step();
      chk("R8 wait holds", upc, 10);
      step();
      chk("R8 wait still holds", upc, 10);
      mem_ready = 1'b1;
      step();
      chk("R8 leave wait on ready", upc, 11);
      step();
      chk("R6 dispatch opcode 7", upc, 22);
      step(); step();
      chk("R11 back to 0", upc, 0);
      // pass 2: zero false falls through, then wrap
      zero_flag = 1'b0;
      step();
      chk("R5 jump again", upc, 5);
      step();
      chk("R7 zero false increments", upc, 6);
      step();
      chk("R4 plain increment", upc, 7);
      step();
      chk("R5 jump to top", upc, 63);
      chk("R1 ctrl at top", ctrl_word, 16'hA03F);
      step();
      chk("R4 wrap to 0", upc, 0);
      run_en = 1'b0;
      do_reset();
      chk("R2 reset restores default", ctrl_word, dctrl(0));
   endtask

   initial begin
      t_reset();
      t_default(0);
      t_default(5);
      t_hold();
      t_ignore();
      t_patch();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule